// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block sends asynchronous serial frames that carry an address/data marker bit after the data bits. Software writes a byte and its marker value into a holding register. Writing clears the data-empty flag. A state machine moves the holding register into its shifter on a baud tick and sets the flag again. It then drives the line one bit per tick: a low start bit, then the data least significant bit first, then the marker bit, then one or two high stop bits.

On entry to the first stop bit, the machine checks the data-empty flag. If data is pending, that data is loaded at once and its start bit follows the stop bit(s) directly. If nothing is pending, the transmit-end flag is set and the line returns to marking (high) after the stop bit(s). Data written after that check, but before the stop bit(s) finish, still follows without an idle bit.

The two interrupt requests are levels. Each one is a flag masked by its enable.

States and transitions, all taken only on a baud tick:
- IDLE→START when data is pending (load).
- START→DATA.
- DATA→DATA while bits remain.
- DATA→MARK after the last data bit.
- MARK→STOP1 (empty check: load for chaining, or set end).
- STOP1→STOP2 when two stop bits are selected.
- STOP1 or STOP2 → START when a frame was chained or data is now pending (load).
- STOP1 or STOP2 → IDLE otherwise.

Top module: `mp_serial_tx`

## Requirements
- R1: A data write stores the byte and marker value, clears the data-empty flag (`tx_empty`=0) and clears the transmit-end flag (`tx_end`=0).
- R2: On a baud tick in IDLE with data pending, the holding register is loaded into the shifter, `tx_empty` returns to 1 and the start bit (0) appears on `txd` after that edge.
- R3: A frame on `txd` is: start 0; then 8 data bits (`cfg_len8`=1) or 7 data bits (`cfg_len8`=0), least significant bit first; then the marker bit; then one stop bit of 1 (`cfg_stop2`=0) or two (`cfg_stop2`=1).
- R4: Every bit lasts exactly one baud tick period, and the line is 1 whenever no frame is being sent.
- R5: If data is pending on the tick that begins the first stop bit, it is loaded then (`tx_empty` goes to 1) and its start bit directly follows the last stop bit.
- R6: If no data is pending on that tick, `tx_end` goes to 1, the stop bit(s) complete and the line then stays at 1.
- R7: Data written after the stop-bit check, but before the stop bit(s) end, is loaded on the tick that ends the last stop bit, with no idle bit in between.
- R8: Data length and stop count are taken when a frame is loaded, so a configuration write during a frame affects only later frames.
- R9: The marker value is captured with its own data byte, so each frame carries the marker value written for it.
- R10: `irq_empty` = `tx_empty` AND `cfg_ie_empty`, and `irq_end` = `tx_end` AND `cfg_ie_end`, at all times.
- R11: After reset `txd`=1, `tx_empty`=1 and `tx_end`=1, with 8 data bits, one stop bit and both interrupt enables off.
- R12: A data write in the same cycle as a load leaves the new data pending (`tx_empty`=0); the load takes the older holding content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_en | input | 1 | Write strobe for holding data and marker |
| wr_data | input | DATA_W | Data byte to send |
| wr_flag | input | 1 | Marker bit value for this byte |
| wr_cfg_en | input | 1 | Write strobe for configuration |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_ie_empty | input | 1 | Data-empty interrupt enable |
| cfg_ie_end | input | 1 | Transmit-end interrupt enable |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line |
| tx_empty | output | 1 | Data-empty flag |
| tx_end | output | 1 | Transmit-end flag |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
Every result falls due on the clock edge that samples its cause, so it is visible one cycle after the stimulus.
- A write changes `tx_empty` and `tx_end` on the next edge.
- A baud tick moves `txd` to the next bit on the edge where the tick is high.
- The load on that same edge sets `tx_empty` again, and the stop-bit check sets `tx_end`.

The bench keeps a behavioural model: a queue of pending line bits plus flag variables. It advances the model on each rising edge using the inputs held over that edge, and compares all five outputs with the model 1 ns after the edge, on every cycle. The stimulus, including the tick, comes from one process at the falling edge, so a write can be placed exactly on a tick cycle.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MARK,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    typedef struct packed {
        logic len8;
        logic stop2;
        logic ie_empty;
        logic ie_end;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{len8: 1'b1, stop2: 1'b0, ie_empty: 1'b0, ie_end: 1'b0};

endpackage

// File: rtl/mpt_cfg.sv
module mpt_cfg
    import mpt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_cfg,
    input  tx_cfg_t cfg_in,
    output tx_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_cfg) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/mpt_hold.sv
module mpt_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_flag,
    input  logic              load,
    input  logic              set_end,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_flag,
    output logic              empty_q,
    output logic              end_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_flag <= 1'b0;
        end else if (wr) begin
            hold_data <= wr_data;
            hold_flag <= wr_flag;
        end
    end

    // A write wins over a load or an end event in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else begin
            if (wr)           empty_q <= 1'b0;
            else if (load)    empty_q <= 1'b1;
            if (wr)           end_q   <= 1'b0;
            else if (set_end) end_q   <= 1'b1;
        end
    end

    assert_wr_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!empty_q && !end_q));

    assert_load_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr) |=> empty_q);

    assert_load_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !empty_q);

    assert_end_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_q) |-> $past(set_end));

    assert_end_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_end |-> empty_q);

endmodule

// File: rtl/mpt_fsm.sv
module mpt_fsm
    import mpt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              empty,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_flag,
    input  logic              cfg_len8,
    input  logic              cfg_stop2,
    output logic              load,
    output logic              set_end,
    output logic              txd
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    tx_state_t         st, st_nxt;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              mark_q;
    logic              len8_q;
    logic              stop2_q;
    logic              two_q;
    logic              chain_q;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = len8_q ? LAST_LONG : LAST_SHORT;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state and control strobes
    always_comb begin
        st_nxt  = st;
        load    = 1'b0;
        set_end = 1'b0;
        if (tick) begin
            unique case (st)
                ST_IDLE: begin
                    if (!empty) begin
                        load   = 1'b1;
                        st_nxt = ST_START;
                    end
                end
                ST_START: st_nxt = ST_DATA;
                ST_DATA: begin
                    if (cnt_q == last_idx) st_nxt = ST_MARK;
                end
                ST_MARK: begin
                    st_nxt = ST_STOP1;
                    if (!empty) load    = 1'b1;
                    else        set_end = 1'b1;
                end
                ST_STOP1, ST_STOP2: begin
                    if (st == ST_STOP1 && two_q) begin
                        st_nxt = ST_STOP2;
                    end else if (chain_q) begin
                        st_nxt = ST_START;
                    end else if (!empty) begin
                        load   = 1'b1;
                        st_nxt = ST_START;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // Shifter and per-frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            mark_q  <= 1'b0;
            len8_q  <= 1'b1;
            stop2_q <= 1'b0;
            two_q   <= 1'b0;
            chain_q <= 1'b0;
        end else if (tick) begin
            if (st == ST_DATA) begin
                sh_q  <= sh_q >> 1;
                cnt_q <= cnt_q + 1'b1;
            end
            if (st == ST_MARK) begin
                two_q   <= stop2_q;
                chain_q <= !empty;
            end
            if (st_nxt == ST_START) chain_q <= 1'b0;
            if (load) begin
                sh_q    <= hold_data;
                mark_q  <= hold_flag;
                len8_q  <= cfg_len8;
                stop2_q <= cfg_stop2;
                cnt_q   <= '0;
            end
        end
    end

    // Line output
    always_comb begin
        unique case (st)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sh_q[0];
            ST_MARK:  txd = mark_q;
            default:  txd = 1'b1;
        endcase
    end

    assert_hold_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st));

    assert_mark_to_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_MARK) |=> (st == ST_STOP1));

    assert_start_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st != ST_MARK) |=> (st == ST_START && !txd));

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && set_end));

endmodule

// File: rtl/mp_serial_tx.sv
module mp_serial_tx
    import mpt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_flag,
    input  logic              wr_cfg_en,
    input  logic              cfg_len8,
    input  logic              cfg_stop2,
    input  logic              cfg_ie_empty,
    input  logic              cfg_ie_end,
    input  logic              baud_tick,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_end,
    output logic              irq_empty,
    output logic              irq_end
);

    tx_cfg_t           cfg_in, cfg_q;
    logic [DATA_W-1:0] hold_data;
    logic              hold_flag;
    logic              load, set_end;

    assign cfg_in = '{len8: cfg_len8, stop2: cfg_stop2,
                      ie_empty: cfg_ie_empty, ie_end: cfg_ie_end};

    mpt_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (wr_cfg_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    mpt_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_data_en),
        .wr_data   (wr_data),
        .wr_flag   (wr_flag),
        .load      (load),
        .set_end   (set_end),
        .hold_data (hold_data),
        .hold_flag (hold_flag),
        .empty_q   (tx_empty),
        .end_q     (tx_end)
    );

    mpt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .empty     (tx_empty),
        .hold_data (hold_data),
        .hold_flag (hold_flag),
        .cfg_len8  (cfg_q.len8),
        .cfg_stop2 (cfg_q.stop2),
        .load      (load),
        .set_end   (set_end),
        .txd       (txd)
    );

    assign irq_empty = tx_empty & cfg_q.ie_empty;
    assign irq_end   = tx_end   & cfg_q.ie_end;

    assert_mask_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg_en && !cfg_ie_empty) |=> !irq_empty);

    assert_mask_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg_en && !cfg_ie_end) |=> !irq_end);

endmodule

// File: tb/mp_serial_tx_test.sv
`timescale 1ns/1ps
module mp_serial_tx_test;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_flag = 1'b0;
    logic       wr_cfg_en = 1'b0;
    logic       cfg_len8 = 1'b1, cfg_stop2 = 1'b0, cfg_ie_empty = 1'b0, cfg_ie_end = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, tx_empty, tx_end, irq_empty, irq_end;

    int checks = 0;
    int errors = 0;
    int div = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mp_serial_tx #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr_data_en), .wr_data(wr_data), .wr_flag(wr_flag),
        .wr_cfg_en(wr_cfg_en), .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2),
        .cfg_ie_empty(cfg_ie_empty), .cfg_ie_end(cfg_ie_end),
        .baud_tick(baud_tick), .txd(txd), .tx_empty(tx_empty), .tx_end(tx_end),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    // ---------------- behavioural reference model ----------------
    bit        q_bit[$];
    bit        q_chk[$];
    bit        m_txd = 1, m_empty = 1, m_end = 1;
    bit [7:0]  m_hold = 0;
    bit        m_hflag = 0;
    bit        m_len8 = 1, m_stop2 = 0, m_ie_e = 0, m_ie_t = 0;
    bit        compare_on = 0;

    function automatic void push_frame();
        q_bit.push_back(1'b0); q_chk.push_back(1'b0);
        for (int i = 0; i < (m_len8 ? 8 : 7); i++) begin
            q_bit.push_back(m_hold[i]); q_chk.push_back(1'b0);
        end
        q_bit.push_back(m_hflag); q_chk.push_back(1'b0);
        q_bit.push_back(1'b1);    q_chk.push_back(1'b1);
        if (m_stop2) begin
            q_bit.push_back(1'b1); q_chk.push_back(1'b0);
        end
        m_empty = 1;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_bit.delete(); q_chk.delete();
            m_txd = 1; m_empty = 1; m_end = 1;
            m_len8 = 1; m_stop2 = 0; m_ie_e = 0; m_ie_t = 0;
        end else begin
            if (baud_tick) begin
                if (q_bit.size() > 0) begin
                    bit c;
                    m_txd = q_bit.pop_front();
                    c = q_chk.pop_front();
                    if (c) begin
                        if (!m_empty) push_frame();
                        else m_end = 1;
                    end
                end else if (!m_empty) begin
                    push_frame();
                    m_txd = q_bit.pop_front();
                    void'(q_chk.pop_front());
                end else begin
                    m_txd = 1;
                end
            end
            if (wr_data_en) begin
                m_hold = wr_data; m_hflag = wr_flag; m_empty = 0; m_end = 0;
            end
            if (wr_cfg_en) begin
                m_len8 = cfg_len8; m_stop2 = cfg_stop2; m_ie_e = cfg_ie_empty; m_ie_t = cfg_ie_end;
            end
        end
        #1;
        if (compare_on && rst_n) begin
            check("R3 R4 R5 R7 R8 R9", "txd", txd, m_txd);
            check("R1 R2 R5 R12", "tx_empty", tx_empty, m_empty);
            check("R1 R6", "tx_end", tx_end, m_end);
            check("R10", "irq_empty", irq_empty, m_empty & m_ie_e);
            check("R10", "irq_end", irq_end, m_end & m_ie_t);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk);
        wr_data_en = 0;
        wr_cfg_en  = 0;
        baud_tick  = (div == DIV - 1);
        div        = (div == DIV - 1) ? 0 : div + 1;
    endtask

    task automatic put(input logic [7:0] d, input logic f);
        step();
        wr_data_en = 1; wr_data = d; wr_flag = f;
    endtask

    task automatic set_cfg(input logic l8, input logic s2, input logic ie, input logic te);
        step();
        wr_cfg_en = 1; cfg_len8 = l8; cfg_stop2 = s2; cfg_ie_empty = ie; cfg_ie_end = te;
    endtask

    task automatic wait_idle();
        step();
        while (!(tx_end && tx_empty && q_bit.size() == 0)) step();
        repeat (2 * DIV) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "txd reset", txd, 1'b1);
        check("R11", "tx_empty reset", tx_empty, 1'b1);
        check("R11", "tx_end reset", tx_end, 1'b1);
        check("R11", "irq_empty reset", irq_empty, 1'b0);
        rst_n = 1;
        compare_on = 1;
        repeat (5) step();

        // R1 R2 R3 R6 R9: one 8-bit frame, one stop, marker 1, interrupts enabled
        set_cfg(1, 0, 1, 1);
        put(8'hA5, 1);
        wait_idle();

        // R3 R9: 7-bit frame, two stop bits, marker 0
        set_cfg(0, 1, 1, 1);
        put(8'h3C, 0);
        wait_idle();

        // R5: chained frames, next byte written as soon as the shifter takes the previous
        set_cfg(1, 1, 1, 0);
        put(8'h81, 1);
        step(); while (tx_empty) step();
        while (!tx_empty) step();
        put(8'h7E, 0);
        while (!tx_empty) step();
        put(8'h55, 1);
        wait_idle();

        // R7: write after the stop-bit check (tx_end just rose), two stop bits
        set_cfg(1, 1, 0, 1);
        put(8'hC3, 0);
        step(); while (!tx_end) step();
        put(8'h1F, 1);
        wait_idle();

        // R8: configuration change in mid-frame applies to the next frame only
        set_cfg(1, 0, 1, 1);
        put(8'hF0, 1);
        step(); while (!tx_empty) step();
        repeat (DIV * 3) step();
        set_cfg(0, 1, 1, 1);
        repeat (DIV * 2) step();
        put(8'h0F, 0);
        wait_idle();

        // R12: second write lands on the load tick; first byte goes, second stays pending
        set_cfg(1, 0, 1, 1);
        put(8'h96, 1);
        step(); while (!baud_tick) step();
        wr_data_en = 1; wr_data = 8'h69; wr_flag = 0;
        wait_idle();

        // R10: masking the enables drops the requests
        set_cfg(1, 0, 0, 0);
        repeat (3) step();
        check("R10", "irq_empty masked", irq_empty, 1'b0);
        check("R10", "irq_end masked", irq_end, 1'b0);
        check("R4", "line idle", txd, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule